// File: doc/BRIEF.md
# Biased Feedback Combiner

This block merges two unipolar sample channels that carry a fixed bias offset (mid-scale stands for zero) into one feedback sample. With both channels enabled it forms channel 0 plus or minus channel 1, and it corrects the arithmetic so that the bias appears once in the result. With only channel 0 enabled it either forwards channel 0 unchanged or mirrors it around the bias. A final selector picks between the combined result and a plain copy of channel 0.

The block is a fixed two-stage pipeline. The first stage samples the data together with the control bits and decodes them into one signed correction term. The second stage adds that term to channel 0, clamps the sum into the sample range, and applies the output selector. A valid flag travels with the data. A change on the control bits therefore affects only samples that enter after it.

Top module: `fb_combiner`

## Requirements
- R1: With `dual_input`=1 and `fb_positive`=1, the output sample is s0 + s1 − BIAS, clamped as in R6.
- R2: With `dual_input`=1 and `fb_positive`=0, the output sample is s0 − s1 + BIAS, clamped as in R6.
- R3: With `dual_input`=0 and `fb_positive`=0, the output sample is 2·BIAS − s0, clamped as in R6, and s1 has no effect.
- R4: With `dual_input`=0 and `fb_positive`=1, the output sample equals s0, and s1 has no effect.
- R5: With `out_sel`=0 the output sample equals s0 whatever the mode bits are. With `out_sel`=1 it is the combined result of R1 to R4.
- R6: Every combined result is saturated into the range 0 to 2^DATA_W − 1: a negative value gives 0 and a value above the top gives the maximum.
- R7: A sample and its control bits driven before clock edge n appear on `out_sample` after edge n+1. `out_valid` carries `in_valid` along the same two-edge path.
- R8: While reset is asserted, both pipeline valid flags are cleared, so `out_valid` is 0 during reset and on the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_s0 | input | DATA_W | Channel 0 sample, biased unsigned |
| in_s1 | input | DATA_W | Channel 1 sample, biased unsigned |
| fb_positive | input | 1 | 1 = positive feedback (add), 0 = negative feedback (subtract or invert) |
| dual_input | input | 1 | 1 = both channels used, 0 = channel 0 only |
| out_sel | input | 1 | 1 = combined result, 0 = channel 0 passthrough |
| out_valid | output | 1 | Output sample qualifier |
| out_sample | output | DATA_W | Output sample, biased unsigned |

## Verification
The bench builds the block with DATA_W=4 and BIAS=10. This small, off-centre configuration makes the full cross product of both channel values, all four mode combinations and both selector settings only 2048 vectors, so the bench sweeps all of it. Because the bias is above mid-scale, the upper clamp is reached by the add path, the subtract path and the inversion path, and the lower clamp is reached by subtraction. The vectors are streamed back to back with a changing valid pattern, so every control change between neighbouring samples is exercised. A reset is also asserted in the middle of the stream.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    typedef enum logic {
        FB_NEGATIVE = 1'b0,
        FB_POSITIVE = 1'b1
    } fb_polarity_e;

    typedef enum logic {
        IN_SINGLE = 1'b0,
        IN_DOUBLE = 1'b1
    } in_mode_e;

    typedef enum logic {
        OUT_PASS    = 1'b0,
        OUT_COMBINE = 1'b1
    } out_choice_e;

    // extra bits so that sums of up to three samples stay exact when signed
    localparam int unsigned GUARD_BITS = 3;

endpackage

// File: rtl/fbc_decode.sv
module fbc_decode
    import fbc_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned BIAS   = 2048,
    localparam int unsigned SW    = DATA_W + GUARD_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_s0,
    input  logic [DATA_W-1:0]    in_s1,
    input  logic                 fb_positive,
    input  logic                 dual_input,
    input  logic                 out_sel,
    output logic                 st_valid,
    output logic [DATA_W-1:0]    st_s0,
    output logic signed [SW-1:0] st_delta,
    output logic                 st_combine
);

    localparam logic signed [SW-1:0] BIAS_S = SW'(BIAS);

    typedef struct packed {
        logic                 valid;
        logic [DATA_W-1:0]    s0;
        logic signed [SW-1:0] delta;
        logic                 combine;
    } stage_t;

    stage_t st_d, st_q;

    logic signed [SW-1:0] s0_x, s1_x;
    fb_polarity_e         pol;
    in_mode_e             mode;

    always_comb begin
        s0_x = $signed({{GUARD_BITS{1'b0}}, in_s0});
        s1_x = $signed({{GUARD_BITS{1'b0}}, in_s1});
        pol  = fb_polarity_e'(fb_positive);
        mode = in_mode_e'(dual_input);

        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.s0      = in_s0;
        st_d.combine = (out_choice_e'(out_sel) == OUT_COMBINE);

        // correction term added to s0 in the next stage
        unique case ({mode, pol})
            {IN_DOUBLE, FB_POSITIVE}: st_d.delta = s1_x - BIAS_S;
            {IN_DOUBLE, FB_NEGATIVE}: st_d.delta = BIAS_S - s1_x;
            {IN_SINGLE, FB_NEGATIVE}: st_d.delta = (BIAS_S <<< 1) - (s0_x <<< 1);
            default:                  st_d.delta = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_valid   = st_q.valid;
    assign st_s0      = st_q.s0;
    assign st_delta   = st_q.delta;
    assign st_combine = st_q.combine;

endmodule

// File: rtl/fbc_resolve.sv
module fbc_resolve
    import fbc_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    localparam int unsigned SW    = DATA_W + GUARD_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    input  logic [DATA_W-1:0]    st_s0,
    input  logic signed [SW-1:0] st_delta,
    input  logic                 st_combine,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_sample
);

    localparam logic signed [SW-1:0] TOP_S = SW'((2 ** DATA_W) - 1);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] sample;
    } out_t;

    out_t                 out_d, out_q;
    logic signed [SW-1:0] sum;
    logic [DATA_W-1:0]    clamped;

    always_comb begin
        sum = $signed({{GUARD_BITS{1'b0}}, st_s0}) + st_delta;

        if (sum < 0) begin
            clamped = '0;
        end else if (sum > TOP_S) begin
            clamped = '1;
        end else begin
            clamped = sum[DATA_W-1:0];
        end

        out_d        = out_q;
        out_d.valid  = st_valid;
        out_d.sample = st_combine ? clamped : st_s0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid  = out_q.valid;
    assign out_sample = out_q.sample;

endmodule

// File: rtl/fb_combiner.sv
module fb_combiner
    import fbc_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned BIAS   = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_s0,
    input  logic [DATA_W-1:0] in_s1,
    input  logic              fb_positive,
    input  logic              dual_input,
    input  logic              out_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);

    localparam int unsigned SW = DATA_W + GUARD_BITS;

    logic                 st_valid;
    logic [DATA_W-1:0]    st_s0;
    logic signed [SW-1:0] st_delta;
    logic                 st_combine;

    fbc_decode #(
        .DATA_W (DATA_W),
        .BIAS   (BIAS)
    ) i_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_s0       (in_s0),
        .in_s1       (in_s1),
        .fb_positive (fb_positive),
        .dual_input  (dual_input),
        .out_sel     (out_sel),
        .st_valid    (st_valid),
        .st_s0       (st_s0),
        .st_delta    (st_delta),
        .st_combine  (st_combine)
    );

    fbc_resolve #(
        .DATA_W (DATA_W)
    ) i_resolve (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_valid   (st_valid),
        .st_s0      (st_s0),
        .st_delta   (st_delta),
        .st_combine (st_combine),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

endmodule

// File: rtl/fbc_checker.sv
module fbc_checker #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned BIAS   = 2048
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_s0,
    input logic [DATA_W-1:0] in_s1,
    input logic              fb_positive,
    input logic              dual_input,
    input logic              out_sel,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_sample
);

    localparam int TOP = (2 ** DATA_W) - 1;

    // edges seen since reset release, saturating at 2
    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= 2'd0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    logic primed;
    assign primed = (warm == 2'd2);

    int add_val;
    assign add_val = int'(in_s0) + int'(in_s1) - int'(BIAS);

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (out_valid == $past(in_valid, 2))); // R7

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(out_sel, 2)) |-> (out_sample == $past(in_s0, 2))); // R5

    AST_SINGLE_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(out_sel && !dual_input && fb_positive, 2))
            |-> (out_sample == $past(in_s0, 2))); // R4

    AST_ADD_INRANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(out_sel && dual_input && fb_positive
                         && add_val >= 0 && add_val <= TOP, 2))
            |-> (int'(out_sample) == $past(add_val, 2))); // R1

    AST_SUB_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(out_sel && dual_input && !fb_positive
                         && int'(in_s1) > int'(in_s0) + int'(BIAS), 2))
            |-> (out_sample == '0)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R8

endmodule

bind fb_combiner fbc_checker #(
    .DATA_W (DATA_W),
    .BIAS   (BIAS)
) i_fbc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_s0       (in_s0),
    .in_s1       (in_s1),
    .fb_positive (fb_positive),
    .dual_input  (dual_input),
    .out_sel     (out_sel),
    .out_valid   (out_valid),
    .out_sample  (out_sample)
);

// File: tb/test_fb_combiner.sv
module test_fb_combiner;

    localparam int DW   = 4;
    localparam int BIAS = 10;
    localparam int TOP  = (2 ** DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_s0 = '0;
    logic [DW-1:0] in_s1 = '0;
    logic          fb_positive = 1'b0;
    logic          dual_input = 1'b0;
    logic          out_sel = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_sample;

    int n_checks = 0;
    int n_fail   = 0;

    // expectations for the vectors driven one and two negedges ago
    int    exp_val [2];
    bit    exp_vld [2];
    string exp_tag [2];
    bit    exp_live[2];

    always #5 clk = ~clk;

    fb_combiner #(
        .DATA_W (DW),
        .BIAS   (BIAS)
    ) i_fb_combiner (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_s0       (in_s0),
        .in_s1       (in_s1),
        .fb_positive (fb_positive),
        .dual_input  (dual_input),
        .out_sel     (out_sel),
        .out_valid   (out_valid),
        .out_sample  (out_sample)
    );

    function automatic int sat(input int v);
        if (v < 0) return 0;
        if (v > TOP) return TOP;
        return v;
    endfunction

    function automatic int model(input int s0, input int s1, input bit pos,
                                 input bit dual, input bit sel);
        if (!sel) return s0;
        if (dual) return pos ? sat(s0 + s1 - BIAS) : sat(s0 - s1 + BIAS);
        return pos ? s0 : sat(2 * BIAS - s0);
    endfunction

    function automatic string tag_of(input int s0, input int s1, input bit pos,
                                     input bit dual, input bit sel);
        int raw;
        if (!sel) return "R5";
        if (dual) raw = pos ? (s0 + s1 - BIAS) : (s0 - s1 + BIAS);
        else raw = pos ? s0 : (2 * BIAS - s0);
        if (raw < 0 || raw > TOP) return "R6";
        if (dual) return pos ? "R1" : "R2";
        return pos ? "R4" : "R3";
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int idx = 0;
        exp_live[0] = 0;
        exp_live[1] = 0;

        // reset state, R8
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", "out_valid in reset", int'(out_valid), 0);
        check("R8", "out_sample in reset", int'(out_sample), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "out_valid first edge after reset", int'(out_valid), 0);
        in_valid = 1'b0;
        @(negedge clk);

        // full sweep streamed back to back: R1-R6 values, R7 timing
        for (int m = 0; m < 8; m++) begin
            for (int a = 0; a <= TOP; a++) begin
                for (int b = 0; b <= TOP; b++) begin
                    if (exp_live[1]) begin
                        check(exp_tag[1], "out_sample", int'(out_sample), exp_val[1]);
                        check("R7", "out_valid", int'(out_valid), int'(exp_vld[1]));
                    end
                    in_s0       = DW'(a);
                    in_s1       = DW'(b);
                    fb_positive = m[0];
                    dual_input  = m[1];
                    out_sel     = m[2];
                    in_valid    = ((idx % 3) != 1);
                    exp_val[1]  = exp_val[0];
                    exp_vld[1]  = exp_vld[0];
                    exp_tag[1]  = exp_tag[0];
                    exp_live[1] = exp_live[0];
                    exp_val[0]  = model(a, b, m[0], m[1], m[2]);
                    exp_vld[0]  = in_valid;
                    exp_tag[0]  = tag_of(a, b, m[0], m[1], m[2]);
                    exp_live[0] = 1'b1;
                    idx++;
                    @(negedge clk);
                end
            end
        end
        for (int k = 0; k < 2; k++) begin
            check(exp_tag[1], "out_sample drain", int'(out_sample), exp_val[1]);
            check("R7", "out_valid drain", int'(out_valid), int'(exp_vld[1]));
            exp_val[1] = exp_val[0];
            exp_vld[1] = exp_vld[0];
            exp_tag[1] = exp_tag[0];
            in_valid   = 1'b1;
            exp_vld[0] = 1'b1;
            @(negedge clk);
        end

        // R3 and R4: s1 has no effect in single-input mode
        dual_input = 1'b0;
        out_sel    = 1'b1;
        for (int p = 0; p < 2; p++) begin
            fb_positive = p[0];
            in_s0 = DW'(3);
            in_s1 = DW'(0);
            @(negedge clk);
            in_s1 = DW'(TOP);
            @(negedge clk);
            check(p ? "R4" : "R3", "s1 ignored (s1=0)", int'(out_sample),
                  p ? 3 : sat(2 * BIAS - 3));
            @(negedge clk);
            check(p ? "R4" : "R3", "s1 ignored (s1=max)", int'(out_sample),
                  p ? 3 : sat(2 * BIAS - 3));
        end

        // reset in mid stream, R8
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R7", "out_valid steady high", int'(out_valid), 1);
        rst_n = 1'b0;
        #1;
        check("R8", "out_valid at reset assert", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "out_valid one edge after release", int'(out_valid), 0);
        @(negedge clk);
        check("R7", "out_valid two edges after release", int'(out_valid), 1);

        finish_run();
    end

endmodule